// File: doc/BRIEF.md
# Decode-Stage Equality Branch Resolver

This block settles a branch-if-equal decision while the branch sits in the decode stage of a five-stage pipeline. Each cycle it looks at the word held in the fetch/decode register. If that word is a branch-if-equal and the two operand values supplied from the register file match, the block forms the target address and redirects the program counter. Because the outcome is known one stage before execute, only one younger instruction has been fetched down the wrong path. The block clears that instruction to an all-zero no-op in the same edge that redirects the PC, so a taken branch costs exactly one lost cycle and a not-taken branch costs none.

The PC register and the fetch/decode register are part of the block, so the fetch side can be driven directly: the environment supplies the fetched word for the current PC, together with the operand values for the instruction in decode. A stall input from the wider pipeline freezes both registers. A stall always wins over a redirect. A running count of flushes lets the penalty be checked from outside.

Top module: `brx_decode_branch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pc_o` equals `RESET_PC` (default 0), `ifid_instr_o` and `ifid_pc4_o` are zero, and `flush_cnt_o` is zero.
- R2: `taken_o` is high exactly when bits [31:26] of `ifid_instr_o` equal 6'b000100 and `rs_val_i` equals `rt_val_i`. For any other opcode, including 6'b000101 and the all-zero word, equal operands have no effect.
- R3: In the same cycle, `target_o` equals `ifid_pc4_o` plus the sign-extended bits [15:0] of `ifid_instr_o` shifted left by two. The sum is taken modulo 2^PC_W.
- R4: When `stall_i` is low and no branch is taken, each edge adds 4 to `pc_o`. On that edge the fetch/decode register also loads `fetch_instr_i` and the old `pc_o`+4.
- R5: When a branch is taken and `stall_i` is low, `flush_o` is high in that cycle. On the next edge `pc_o` loads `target_o` and `ifid_instr_o` and `ifid_pc4_o` become zero.
- R6: A taken branch discards exactly one instruction. One edge after the flush, decode holds the word fetched at the target, with `ifid_pc4_o` equal to the target plus 4, and no second flush follows.
- R7: While `stall_i` is high, `pc_o`, `ifid_instr_o`, `ifid_pc4_o` and `flush_cnt_o` hold and `flush_o` is low, even if `taken_o` is high. When the stall is released, the branch is evaluated again.
- R8: `flush_cnt_o` rises by one on every edge that follows a cycle with `flush_o` high, holds otherwise, and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze request from the pipeline; wins over a redirect |
| fetch_instr_i | input | 32 | Instruction word fetched at `pc_o` |
| rs_val_i | input | DATA_W | First source operand value of the instruction in decode |
| rt_val_i | input | DATA_W | Second source operand value of the instruction in decode |
| pc_o | output | PC_W | Current fetch address |
| ifid_instr_o | output | 32 | Instruction held in decode |
| ifid_pc4_o | output | PC_W | Incremented PC carried with the decode instruction |
| taken_o | output | 1 | Branch condition met in decode |
| flush_o | output | 1 | Redirect and wrong-path cancel this cycle |
| target_o | output | PC_W | Computed branch target |
| flush_cnt_o | output | CNT_W | Count of flushes performed |

## Verification
The hardest situation to reach from the ports is a taken branch that meets a stall. The redirect must wait without being lost, and it must fire once the stall drops. The vector table has an entry that loads a taken branch into decode and then raises `stall_i` in the same cycle as the equal operands. The bench checks that everything holds, then releases the stall and expects the flush. A second hard case is the wrap of the flush counter. It is reached by fetching the same taken branch over and over, so that a flush happens every other cycle for a little more than one full counter period.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_HI   = 31;
  localparam int OP_LO   = 26;
  localparam int OP_W    = OP_HI - OP_LO + 1;
  localparam int OFF_W   = 16;
  localparam logic [OP_W-1:0]    OP_BEQ   = 6'b000100;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  // opcode field of a decode word
  function automatic logic [OP_W-1:0] op_of(input logic [INSTR_W-1:0] w);
    return w[OP_HI:OP_LO];
  endfunction

  // offset field of a decode word
  function automatic logic [OFF_W-1:0] off_of(input logic [INSTR_W-1:0] w);
    return w[OFF_W-1:0];
  endfunction
endpackage

// File: rtl/brx_resolve.sv
module brx_resolve
  import brx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [PC_W-1:0]   pc4_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  localparam int EXT_W = PC_W - OFF_W;

  function automatic logic [PC_W-1:0] calc_target(input logic [PC_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
    logic [PC_W-1:0] sx;
    sx = {{EXT_W{off[OFF_W-1]}}, off};
    return base + (sx << 2);
  endfunction

  logic is_beq_w;
  logic eq_w;

  assign is_beq_w = (op_i == OP_BEQ);
  assign eq_w     = (a_i == b_i);
  assign taken_o  = is_beq_w & eq_w;
  assign target_o = calc_target(pc4_i, off_i);
endmodule

// File: rtl/brx_pc_reg.sv
module brx_pc_reg #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pc4_o
);
  logic [PC_W-1:0] pc_q;

  assign pc4_o = pc_q + PC_W'(4);
  assign pc_o  = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          pc_q <= RESET_PC;
    else if (hold_i)     pc_q <= pc_q;
    else if (redirect_i) pc_q <= target_i;
    else                 pc_q <= pc4_o;
  end
endmodule

// File: rtl/brx_ifid_reg.sv
module brx_ifid_reg
  import brx_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               flush_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [PC_W-1:0]    pc4_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [PC_W-1:0]    pc4_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr_o <= NOP_WORD;
      pc4_o   <= '0;
    end else if (hold_i) begin
      instr_o <= instr_o;
      pc4_o   <= pc4_o;
    end else if (flush_i) begin
      instr_o <= NOP_WORD;
      pc4_o   <= '0;
    end else begin
      instr_o <= instr_i;
      pc4_o   <= pc4_i;
    end
  end
endmodule

// File: rtl/brx_flush_ctr.sv
module brx_flush_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/brx_decode_branch.sv
module brx_decode_branch
  import brx_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              PC_W     = 32,
  parameter int              CNT_W    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] ifid_instr_o,
  output logic [PC_W-1:0]    ifid_pc4_o,
  output logic               taken_o,
  output logic               flush_o,
  output logic [PC_W-1:0]    target_o,
  output logic [CNT_W-1:0]   flush_cnt_o
);
  // named internal events
  logic            taken_w;
  logic            flush_w;
  logic [PC_W-1:0] target_w;
  logic [PC_W-1:0] fetch_pc4_w;

  // stall wins: a taken branch waits in decode until released
  assign flush_w = taken_w & ~stall_i;

  brx_resolve #(.DATA_W(DATA_W), .PC_W(PC_W)) resolve_i (
    .op_i     (op_of(ifid_instr_o)),
    .off_i    (off_of(ifid_instr_o)),
    .pc4_i    (ifid_pc4_o),
    .a_i      (rs_val_i),
    .b_i      (rt_val_i),
    .taken_o  (taken_w),
    .target_o (target_w)
  );

  brx_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) pc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (stall_i),
    .redirect_i (flush_w),
    .target_i   (target_w),
    .pc_o       (pc_o),
    .pc4_o      (fetch_pc4_w)
  );

  brx_ifid_reg #(.PC_W(PC_W)) ifid_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (stall_i),
    .flush_i (flush_w),
    .instr_i (fetch_instr_i),
    .pc4_i   (fetch_pc4_w),
    .instr_o (ifid_instr_o),
    .pc4_o   (ifid_pc4_o)
  );

  brx_flush_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (flush_w),
    .cnt_o (flush_cnt_o)
  );

  assign taken_o  = taken_w;
  assign flush_o  = flush_w;
  assign target_o = target_w;
endmodule

// File: rtl/brx_decode_branch_chk.sv
module brx_decode_branch_chk #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_i,
  input logic             flush_o,
  input logic [PC_W-1:0]  pc_o,
  input logic [31:0]      ifid_instr_o,
  input logic [PC_W-1:0]  ifid_pc4_o,
  input logic [PC_W-1:0]  target_o,
  input logic [CNT_W-1:0] flush_cnt_o
);
  // R5: redirect loads the target
  a_r5_redirect_pc: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> pc_o == $past(target_o));

  // R5: wrong-path word becomes a no-op
  a_r5_clear_ifid: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (ifid_instr_o == '0) && (ifid_pc4_o == '0));

  // R6: only one instruction is discarded per taken branch
  a_r6_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  // R4: sequential advance
  a_r4_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !flush_o) |=> pc_o == $past(pc_o) + PC_W'(4));

  // R7: stall freezes the front end
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_o) && $stable(ifid_instr_o) && $stable(ifid_pc4_o));

  // R8: counter steps by one per flush
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> flush_cnt_o == $past(flush_cnt_o) + CNT_W'(1));

  // R8: counter holds without a flush
  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |=> $stable(flush_cnt_o));
endmodule

bind brx_decode_branch brx_decode_branch_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall_i      (stall_i),
  .flush_o      (flush_o),
  .pc_o         (pc_o),
  .ifid_instr_o (ifid_instr_o),
  .ifid_pc4_o   (ifid_pc4_o),
  .target_o     (target_o),
  .flush_cnt_o  (flush_cnt_o)
);

// File: tb/brx_decode_branch_tb_top.sv
`timescale 1ns/1ps
module brx_decode_branch_tb_top;
  localparam int DW = 32;
  localparam int PW = 32;
  localparam int CW = 8;
  localparam logic [31:0] MARK = 32'h2000_0001; // non-branch opcode 001000

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall;
  logic [31:0]   fetch;
  logic [DW-1:0] a, b;
  logic [PW-1:0] pc, ifid_pc4, target;
  logic [31:0]   ifid_instr;
  logic          taken, flush;
  logic [CW-1:0] cnt;

  always #2 clk = ~clk; // 250 MHz

  brx_decode_branch #(.DATA_W(DW), .PC_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .fetch_instr_i(fetch),
    .rs_val_i(a), .rt_val_i(b), .pc_o(pc), .ifid_instr_o(ifid_instr),
    .ifid_pc4_o(ifid_pc4), .taken_o(taken), .flush_o(flush),
    .target_o(target), .flush_cnt_o(cnt)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] va;
    logic [31:0] vb;
    logic        st;
    logic        exp_taken;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h1022_0004, 32'd5,         32'd5,         1'b0, 1'b1},
    '{32'h1022_0004, 32'd5,         32'd6,         1'b0, 1'b0},
    '{32'h1400_0003, 32'd7,         32'd7,         1'b0, 1'b0},
    '{32'h1000_FFFF, 32'd0,         32'd0,         1'b0, 1'b1},
    '{32'h1000_8000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1},
    '{32'h1000_7FFF, 32'd1,         32'd1,         1'b1, 1'b1},
    '{32'h0000_0000, 32'd0,         32'd0,         1'b0, 1'b0},
    '{32'h1000_0010, 32'h8000_0000, 32'd0,         1'b0, 1'b0},
    '{32'h2002_0002, 32'd3,         32'd3,         1'b1, 1'b0}
  };

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] exp_pc;
  int exp_cnt;

  // offset scaled to bytes, added to the incremented PC
  function automatic logic [31:0] tb_target(input logic [31:0] base, input logic [31:0] w);
    logic signed [31:0] byte_off;
    byte_off = 32'($signed(w[15:0])) * 4;
    return base + byte_off;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; fetch = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(pc == 32'd0, "R1 pc", pc, 32'd0);
    check(ifid_instr == 32'd0, "R1 ifid_instr", ifid_instr, 32'd0);
    check(ifid_pc4 == 32'd0, "R1 ifid_pc4", ifid_pc4, 32'd0);
    check(cnt == '0, "R1 count", 32'(cnt), 32'd0);
    rst_n   = 1'b1;
    exp_pc  = 32'd0;
    exp_cnt = 0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] tgt;
      v = VECS[i];
      // load the vector word into decode
      fetch = v.instr; stall = 1'b0; a = '0; b = '1;
      step();
      exp_pc = exp_pc + 32'd4;
      check(ifid_instr == v.instr, "R4 decode load", ifid_instr, v.instr);
      check(ifid_pc4 == exp_pc, "R4 pc4 carried", ifid_pc4, exp_pc);
      check(pc == exp_pc, "R4 pc advance", pc, exp_pc);
      // present operands
      fetch = MARK; a = v.va; b = v.vb; stall = v.st;
      #1;
      tgt = tb_target(exp_pc, v.instr);
      check(taken == v.exp_taken, "R2 taken", 32'(taken), 32'(v.exp_taken));
      check(target == tgt, "R3 target", target, tgt);
      check(flush == (v.exp_taken && !v.st), "R5 flush level", 32'(flush),
            32'(v.exp_taken && !v.st));
      if (v.st) begin
        step();
        check(pc == exp_pc, "R7 pc held", pc, exp_pc);
        check(ifid_instr == v.instr, "R7 decode held", ifid_instr, v.instr);
        check(cnt == CW'(exp_cnt), "R7 count held", 32'(cnt), 32'(exp_cnt));
        stall = 1'b0;
        #1;
        check(flush == v.exp_taken, "R7 re-evaluated after release", 32'(flush),
              32'(v.exp_taken));
      end
      step();
      if (v.exp_taken) begin
        exp_pc = tgt;
        exp_cnt++;
        check(pc == exp_pc, "R5 pc redirect", pc, exp_pc);
        check(ifid_instr == 32'd0, "R5 decode cleared", ifid_instr, 32'd0);
      end else begin
        exp_pc = exp_pc + 32'd4;
        check(pc == exp_pc, "R4 pc not taken", pc, exp_pc);
        check(ifid_instr == MARK, "R4 next word", ifid_instr, MARK);
      end
      check(cnt == CW'(exp_cnt), "R8 count", 32'(cnt), 32'(exp_cnt));
      // one more edge: the target word enters decode
      #1;
      check(flush == 1'b0, "R6 no second flush", 32'(flush), 32'd0);
      step();
      if (v.exp_taken) begin
        check(ifid_instr == MARK, "R6 target word in decode", ifid_instr, MARK);
        check(ifid_pc4 == tgt + 32'd4, "R6 target pc4", ifid_pc4, tgt + 32'd4);
      end
      exp_pc = exp_pc + 32'd4;
      check(pc == exp_pc, "R4 pc after", pc, exp_pc);
    end

    // R8 wrap: a taken branch fetched repeatedly flushes every other edge
    fetch = 32'h1000_0000; a = 32'd9; b = 32'd9; stall = 1'b0;
    for (int k = 0; k < 520; k++) step();
    exp_cnt = exp_cnt + 260;
    check(cnt == CW'(exp_cnt), "R8 count wrap", 32'(cnt), 32'(CW'(exp_cnt)));

    // R1 mid-run reset
    rst_n = 1'b0;
    step();
    check(pc == 32'd0, "R1 pc after reset", pc, 32'd0);
    check(cnt == '0, "R1 count after reset", 32'(cnt), 32'd0);
    check(ifid_instr == 32'd0, "R1 decode after reset", ifid_instr, 32'd0);
    finish_run();
  end
endmodule